// File: doc/BRIEF.md
# Bidirectional Timer Counter Unit

The block is the counting core of an 8-bit timer. A register holds the count. On each qualified timer tick it is cleared, stepped up by one or stepped down by one. A qualified tick is a cycle where the clock-select field is nonzero and the count-enable pulse is high. The pulse comes from a prescaler outside the block, so the block itself divides nothing. A select code of zero stops the counter completely.

Three indications follow the count combinationally:
- bottom, when the count is zero;
- max, when the count is all ones;
- top, when the count equals the end of the current sequence.

The end of the sequence is either the fixed all-ones value or a compare value supplied from outside. A sticky overflow request flag records an upward wrap from all ones to zero. Software clears the flag by writing one to a clear input.

Top module: `bidir_tmr_cnt`

## Requirements
- R1: While reset is asserted, and after it is released, the count reads 0x00 and the overflow flag reads 0 until the first qualified tick.
- R2: When the clock select is 000, the count holds its value whatever the tick, clear and direction inputs do.
- R3: With a nonzero clock select, the count changes only on cycles where the tick input is high. It changes one cycle later, at the next clock edge.
- R4: On a qualified tick with clear low and direction 0 (up), the count increases by one and wraps from 0xFF to 0x00.
- R5: On a qualified tick with clear low and direction 1 (down), the count decreases by one and wraps from 0x00 to 0xFF.
- R6: On a qualified tick with clear high, the count becomes 0x00 in either direction. Clear has priority over counting, and clear has no effect on cycles that are not a qualified tick.
- R7: The bottom output is 1 exactly when the count is 0x00. The max output is 1 exactly when the count is 0xFF.
- R8: With top select 0, the top output is 1 when the count is 0xFF. With top select 1, the top output is 1 when the count equals the compare input.
- R9: The overflow flag is set after a qualified upward tick taken at count 0xFF with clear low. It is not set by a downward wrap or by a clear at 0xFF. Once set, it stays set.
- R10: A write-one-to-clear pulse resets the overflow flag at the next edge. If a set condition occurs in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 3 | Clock select; 000 stops the counter |
| tick_i | input | 1 | Single-cycle count-enable pulse from the prescaler |
| dir_down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| clear_i | input | 1 | Synchronous clear, taken on a qualified tick |
| top_sel_i | input | 1 | Sequence end: 0 is all ones, 1 is the compare value |
| cmp_val_i | input | 8 | Compare register value |
| ovf_wclr_i | input | 1 | Write one to clear the overflow flag |
| count_o | output | 8 | Current count |
| at_bottom_o | output | 1 | Count is zero |
| at_max_o | output | 1 | Count is all ones |
| at_top_o | output | 1 | Count equals the selected sequence end |
| ovf_flag_o | output | 1 | Sticky overflow request |

## Verification
A wrong next-count decision, such as a missed tick, a wrong direction, a lost clear priority or a wrap to the wrong value, appears on count_o at the edge that follows the tick. Every check therefore compares the count one cycle after each stimulus. The bound indications are derived combinationally from the count, so a wrong decode is visible in the same cycle. The overflow flag only reveals a mistake at the wrap cycle or the clear cycle. For that reason, the bench tests the upward wrap, the downward wrap, a clear taken at 0xFF and a simultaneous set and clear, and samples the flag one cycle after each.

// File: rtl/tmr_cnt_pkg.sv
package tmr_cnt_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned CSEL_W = 3;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_CLEAR = 2'd1,
    STEP_UP    = 2'd2,
    STEP_DOWN  = 2'd3
  } step_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
  import tmr_cnt_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned SW = CSEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] clk_sel_i,
  input  logic          tick_i,
  input  logic          dir_down_i,
  input  logic          clear_i,
  output logic [W-1:0]  count_o,
  output logic          wrap_up_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic         src_on;
  logic         step_en;
  step_e        step_kind;
  logic [W-1:0] count_q;
  logic [W-1:0] count_d;

  assign src_on  = |clk_sel_i;
  assign step_en = src_on & tick_i;

  always_comb begin
    if (!step_en) begin
      step_kind = STEP_HOLD;
    end else if (clear_i) begin
      step_kind = STEP_CLEAR;
    end else if (dir_down_i) begin
      step_kind = STEP_DOWN;
    end else begin
      step_kind = STEP_UP;
    end
  end

  always_comb begin
    count_d = count_q;
    unique case (step_kind)
      STEP_CLEAR: count_d = '0;
      STEP_UP:    count_d = count_q + ONE;
      STEP_DOWN:  count_d = count_q - ONE;
      default:    count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (step_en) begin
      count_q <= count_d;
    end
  end

  assign count_o   = count_q;
  assign wrap_up_o = (step_kind == STEP_UP) && (count_q == ALL1);
endmodule

// File: rtl/tmr_cnt_bounds.sv
module tmr_cnt_bounds
  import tmr_cnt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic [W-1:0] count_i,
  input  logic         top_sel_i,
  input  logic [W-1:0] cmp_val_i,
  output logic         at_bottom_o,
  output logic         at_max_o,
  output logic         at_top_o
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [W-1:0] top_val;

  always_comb begin
    top_val     = top_sel_i ? cmp_val_i : ALL1;
    at_bottom_o = (count_i == '0);
    at_max_o    = (count_i == ALL1);
    at_top_o    = (count_i == top_val);
  end
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wclr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  assign flag_en = set_i | wclr_i;

  always_comb begin
    flag_d = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bidir_tmr_cnt.sv
module bidir_tmr_cnt
  import tmr_cnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSEL_W-1:0] clk_sel_i,
  input  logic              tick_i,
  input  logic              dir_down_i,
  input  logic              clear_i,
  input  logic              top_sel_i,
  input  logic [CNT_W-1:0]  cmp_val_i,
  input  logic              ovf_wclr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              at_bottom_o,
  output logic              at_max_o,
  output logic              at_top_o,
  output logic              ovf_flag_o
);
  logic rst_n_sync;
  logic wrap_up;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tmr_cnt_core #(.W(CNT_W), .SW(CSEL_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .clk_sel_i  (clk_sel_i),
    .tick_i     (tick_i),
    .dir_down_i (dir_down_i),
    .clear_i    (clear_i),
    .count_o    (count_o),
    .wrap_up_o  (wrap_up)
  );

  tmr_cnt_bounds #(.W(CNT_W)) u_bounds (
    .count_i     (count_o),
    .top_sel_i   (top_sel_i),
    .cmp_val_i   (cmp_val_i),
    .at_bottom_o (at_bottom_o),
    .at_max_o    (at_max_o),
    .at_top_o    (at_top_o)
  );

  tmr_ovf_flag u_ovf (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (wrap_up),
    .wclr_i (ovf_wclr_i),
    .flag_o (ovf_flag_o)
  );
endmodule

// File: rtl/bidir_tmr_cnt_chk.sv
module bidir_tmr_cnt_chk
  import tmr_cnt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CSEL_W-1:0] clk_sel_i,
  input logic              tick_i,
  input logic              dir_down_i,
  input logic              clear_i,
  input logic              ovf_wclr_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              at_bottom_o,
  input logic              at_max_o,
  input logic              ovf_flag_o
);
  logic qual;
  assign qual = (clk_sel_i != '0) && tick_i;

  // R2: stopped source holds the count
  assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == '0) |=> $stable(count_o));

  // R3: no tick, no change
  assert_no_tick_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_o));

  // R4: upward step
  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !clear_i && !dir_down_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

  // R5: downward step
  assert_down_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !clear_i && dir_down_i) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

  // R6: clear wins
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && clear_i) |=> (count_o == '0));

  // R7: bottom and max never together
  assert_bounds_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_bottom_o && at_max_o));

  // R9: sticky flag
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !ovf_wclr_i) |=> ovf_flag_o);

  // R9: downward wrap never raises it
  assert_no_down_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag_o && !(qual && !clear_i && !dir_down_i)) |=> !ovf_flag_o);

  // R10: set wins over write-one-to-clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !clear_i && !dir_down_i && at_max_o) |=> ovf_flag_o);
endmodule

bind bidir_tmr_cnt bidir_tmr_cnt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .clk_sel_i   (clk_sel_i),
  .tick_i      (tick_i),
  .dir_down_i  (dir_down_i),
  .clear_i     (clear_i),
  .ovf_wclr_i  (ovf_wclr_i),
  .count_o     (count_o),
  .at_bottom_o (at_bottom_o),
  .at_max_o    (at_max_o),
  .ovf_flag_o  (ovf_flag_o)
);

// File: tb/sim_bidir_tmr_cnt.sv
`timescale 1ns/1ps
module sim_bidir_tmr_cnt;
  logic       clk;
  logic       rst_n;
  logic [2:0] clk_sel_i;
  logic       tick_i;
  logic       dir_down_i;
  logic       clear_i;
  logic       top_sel_i;
  logic [7:0] cmp_val_i;
  logic       ovf_wclr_i;
  logic [7:0] count_o;
  logic       at_bottom_o;
  logic       at_max_o;
  logic       at_top_o;
  logic       ovf_flag_o;

  int n_chk;
  int n_fail;

  bidir_tmr_cnt u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_sel_i   (clk_sel_i),
    .tick_i      (tick_i),
    .dir_down_i  (dir_down_i),
    .clear_i     (clear_i),
    .top_sel_i   (top_sel_i),
    .cmp_val_i   (cmp_val_i),
    .ovf_wclr_i  (ovf_wclr_i),
    .count_o     (count_o),
    .at_bottom_o (at_bottom_o),
    .at_max_o    (at_max_o),
    .at_top_o    (at_top_o),
    .ovf_flag_o  (ovf_flag_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge, then sample 1 ns later
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic tick_n(input int n, input logic dn);
    dir_down_i = dn;
    tick_i     = 1'b1;
    for (int i = 0; i < n; i++) cyc();
    tick_i     = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 8'h00);
    check("R1 ovf", ovf_flag_o, 0);
    check("R7 bottom at 0", at_bottom_o, 1);
    check("R7 max at 0", at_max_o, 0);
    check("R8 top at 0 fixed", at_top_o, 0);
  endtask

  task automatic t_gating();
    clk_sel_i = 3'b000;
    clear_i   = 1'b0;
    tick_n(5, 1'b0);
    check("R2 stopped hold", count_o, 8'h00);
    clk_sel_i = 3'b000;
    tick_n(3, 1'b1);
    check("R2 stopped hold down", count_o, 8'h00);
    clk_sel_i = 3'b011;
    tick_i = 1'b0;
    cyc(); cyc(); cyc();
    check("R3 no tick hold", count_o, 8'h00);
    tick_n(1, 1'b0);
    cyc();
    tick_n(1, 1'b0);
    check("R3 two ticks", count_o, 8'h02);
  endtask

  task automatic t_up_wrap();
    tick_n(253, 1'b0);
    check("R4 reach max", count_o, 8'hFF);
    check("R7 max", at_max_o, 1);
    check("R8 top fixed at FF", at_top_o, 1);
    check("R9 no flag yet", ovf_flag_o, 0);
    tick_n(1, 1'b0);
    check("R4 wrap to 0", count_o, 8'h00);
    check("R9 flag set", ovf_flag_o, 1);
    cyc(); cyc();
    check("R9 sticky", ovf_flag_o, 1);
    ovf_wclr_i = 1'b1; cyc(); ovf_wclr_i = 1'b0;
    check("R10 wclr", ovf_flag_o, 0);
    tick_n(1, 1'b1);
    check("R5 wrap down to FF", count_o, 8'hFF);
    check("R9 no flag on down wrap", ovf_flag_o, 0);
    tick_n(1, 1'b1);
    check("R5 decrement", count_o, 8'hFE);
    tick_n(1, 1'b0);
    ovf_wclr_i = 1'b1;
    tick_n(1, 1'b0);
    ovf_wclr_i = 1'b0;
    check("R10 set wins", ovf_flag_o, 1);
    check("R4 wrap again", count_o, 8'h00);
    ovf_wclr_i = 1'b1; cyc(); ovf_wclr_i = 1'b0;
    check("R10 cleared", ovf_flag_o, 0);
  endtask

  task automatic t_clear();
    tick_n(5, 1'b0);
    check("R4 five up", count_o, 8'h05);
    clear_i = 1'b1;
    tick_i  = 1'b0;
    cyc();
    check("R6 clear without tick", count_o, 8'h05);
    clk_sel_i = 3'b000;
    tick_n(1, 1'b0);
    check("R6 clear while stopped", count_o, 8'h05);
    clk_sel_i = 3'b001;
    tick_n(1, 1'b1);
    check("R6 clear down", count_o, 8'h00);
    clear_i = 1'b0;
    tick_n(1, 1'b1);
    check("R5 to FF", count_o, 8'hFF);
    clear_i = 1'b1;
    tick_n(1, 1'b0);
    clear_i = 1'b0;
    check("R6 clear up at FF", count_o, 8'h00);
    check("R9 clear at FF no flag", ovf_flag_o, 0);
  endtask

  task automatic t_top();
    top_sel_i = 1'b1;
    cmp_val_i = 8'h03;
    tick_n(3, 1'b0);
    check("R8 top at cmp", at_top_o, 1);
    check("R7 not max", at_max_o, 0);
    check("R7 not bottom", at_bottom_o, 0);
    tick_n(1, 1'b0);
    check("R8 past cmp", at_top_o, 0);
    cmp_val_i = 8'h04;
    #1;
    check("R8 cmp follows", at_top_o, 1);
    top_sel_i = 1'b0;
    #1;
    check("R8 fixed sel", at_top_o, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    clk_sel_i = 3'b000; tick_i = 1'b0; dir_down_i = 1'b0; clear_i = 1'b0;
    top_sel_i = 1'b0; cmp_val_i = 8'h00; ovf_wclr_i = 1'b0;
    cyc(); cyc();
    check("R1 in reset", count_o, 8'h00);
    rst_n = 1'b1;
    cyc(); cyc(); cyc();
    t_reset();
    t_gating();
    t_up_wrap();
    t_clear();
    t_top();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule